// File: doc/BRIEF.md
# NOR Flash Write-Buffer Program Sequencer

This block turns one burst-program request into the bus-write sequence that a NOR flash expects for its write-buffer programming command. A request gives a start word address and a word count. The block first writes two unlock cycles. It then writes the buffer-load command and the count minus one, both to the start address. Next it writes one data word for each stream beat, at consecutive addresses. It ends with the confirm command, sent to the address of the last word it loaded. Each bus access is a single-cycle write strobe with its address and data valid in that same cycle.

Data words arrive on a valid/ready stream. The stream has these back-pressure rules. `s_ready` is high only during the data phase. While it is high the block never stalls the source, so every cycle with `s_valid` high moves exactly one word onto the bus. The source may drop `s_valid` at any time to stall the burst, and the bus stays silent in those cycles. A request with a count of zero, or with a count above the buffer depth, is refused. The block raises a one-cycle error pulse and makes no bus access. Completion polling of the flash is left to other logic, which can start when `done` pulses.

Top module: `nor_wrbuf_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `wr_en`, `s_ready`, `busy`, `done` and `err` are all 0.
- R2: A request is accepted when `start` is high and `busy` is low. The two cycles after an accepted request each carry one write: first address 0x555 with data 0xAA, then address 0x2AA with data 0x55.
- R3: The third write of a sequence carries the buffer-load command 0x25 to the start address.
- R4: The fourth write carries the value count-1, zero-extended to the data width, to the start address.
- R5: Data word i (0-based) is written to address start+i, taken modulo 2^AW. The words are written in stream order, and a burst of N writes exactly N data words.
- R6: `s_ready` is high exactly during the data phase. There, `wr_en` equals `s_valid`, `wr_data` equals `s_data`, and a cycle without `s_valid` produces no write.
- R7: The write after the last data word carries the confirm command 0x29 to the address of that last data word.
- R8: `done` is high for exactly one cycle, the cycle after the confirm write, and `busy` is low in that cycle.
- R9: A request with a count of 0 or a count greater than DEPTH (default 32) produces a one-cycle `err` pulse in the next cycle. It produces no write, `s_ready` stays low and `busy` stays low.
- R10: `start` has no effect while `busy` is high. The running sequence continues unchanged.
- R11: A request presented in the cycle in which `done` is high is accepted, and its first unlock write follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_addr | input | AW | First word address of the burst |
| word_cnt | input | CW | Number of words in the burst |
| s_valid | input | 1 | Data stream valid |
| s_data | input | DW | Data stream word |
| s_ready | output | 1 | Data stream ready (data phase only) |
| wr_en | output | 1 | Single-cycle bus write strobe |
| wr_addr | output | AW | Bus write address |
| wr_data | output | DW | Bus write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the confirm write |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
Two functions can meet in one cycle: the completion pulse of one burst and the acceptance of the next request. The bench provokes this by raising `start` in exactly the cycle its model expects `done`. It then judges that cycle and the following one: `done` is high with `busy` low, and the next cycle holds the 0x555/0xAA unlock write. The opposite case is also driven. There, `start` is held high through several busy cycles, and the bench checks each cycle that the bus keeps following the first request. Error pulses for refused requests are also launched from idle cycles next to bursts, to show they never overlap a sequence.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_UNL1, PH_UNL2, PH_LOAD, PH_COUNT, PH_DATA, PH_CONF
  } phase_t;

  localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLOCK_CODE_A = 8'hAA;
  localparam logic [7:0]  UNLOCK_CODE_B = 8'h55;
  localparam logic [7:0]  CODE_BUF_LOAD = 8'h25;
  localparam logic [7:0]  CODE_CONFIRM  = 8'h29;
endpackage

// File: rtl/nwb_len_check.sv
module nwb_len_check #(
  parameter int CW    = 8,
  parameter int DEPTH = 32
) (
  input  logic [CW-1:0] cnt,
  output logic          ok
);
  // a burst must hold at least one word and fit in the device buffer
  always_comb ok = (cnt != '0) && (int'(cnt) <= DEPTH);
endmodule

// File: rtl/nwb_addr_ctr.sv
module nwb_addr_ctr #(
  parameter int AW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] last_addr,
  output logic [CW-1:0] remain,
  output logic          final_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      last_addr <= '0;
      remain    <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      last_addr <= load_addr;
      remain    <= load_cnt;
    end else if (step) begin
      last_addr <= cur_addr;
      cur_addr  <= cur_addr + 1'b1;
      remain    <= remain - 1'b1;
    end
  end

  always_comb final_word = (remain == CW'(1));

  AST_STEP_RECORDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> last_addr == $past(cur_addr)); // R7
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> cur_addr == $past(cur_addr) + 1'b1); // R5
endmodule

// File: rtl/nor_wrbuf_seq.sv
module nor_wrbuf_seq
  import nwb_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);

  phase_t        phase, phase_nx;
  logic          cnt_ok, accept, step, final_word;
  logic [AW-1:0] cur_addr, last_addr;
  logic [CW-1:0] remain;
  logic [CW-1:0] cnt_m1;
  logic          done_q, err_q;

  nwb_len_check #(.CW(CW), .DEPTH(DEPTH)) u_len (
    .cnt (word_cnt),
    .ok  (cnt_ok)
  );

  assign accept = (phase == PH_IDLE) && start && cnt_ok;
  assign step   = (phase == PH_DATA) && s_valid;

  nwb_addr_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_addr  (start_addr),
    .load_cnt   (word_cnt),
    .step       (step),
    .cur_addr   (cur_addr),
    .last_addr  (last_addr),
    .remain     (remain),
    .final_word (final_word)
  );

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (accept) phase_nx = PH_UNL1;
      PH_UNL1:  phase_nx = PH_UNL2;
      PH_UNL2:  phase_nx = PH_LOAD;
      PH_LOAD:  phase_nx = PH_COUNT;
      PH_COUNT: phase_nx = PH_DATA;
      PH_DATA:  if (s_valid && final_word) phase_nx = PH_CONF;
      PH_CONF:  phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      phase  <= phase_nx;
      done_q <= (phase == PH_CONF);
      err_q  <= (phase == PH_IDLE) && start && !cnt_ok;
    end
  end

  // count register still holds the full count until the first data beat
  assign cnt_m1 = remain - 1'b1;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    unique case (phase)
      PH_UNL1:  begin wr_en = 1'b1; wr_addr = ADDR_A;    wr_data = DW'(UNLOCK_CODE_A); end
      PH_UNL2:  begin wr_en = 1'b1; wr_addr = ADDR_B;    wr_data = DW'(UNLOCK_CODE_B); end
      PH_LOAD:  begin wr_en = 1'b1; wr_addr = cur_addr;  wr_data = DW'(CODE_BUF_LOAD); end
      PH_COUNT: begin wr_en = 1'b1; wr_addr = cur_addr;  wr_data = DW'(cnt_m1);        end
      PH_DATA:  begin wr_en = s_valid; wr_addr = cur_addr; wr_data = s_data;          end
      PH_CONF:  begin wr_en = 1'b1; wr_addr = last_addr; wr_data = DW'(CODE_CONFIRM);  end
      default:  ;
    endcase
  end

  assign s_ready = (phase == PH_DATA);
  assign busy    = (phase != PH_IDLE);
  assign done    = done_q;
  assign err     = err_q;

  AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en && wr_addr == ADDR_A && wr_data == DW'(UNLOCK_CODE_A)); // R2
  AST_SECOND_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> wr_en && wr_addr == ADDR_B && wr_data == DW'(UNLOCK_CODE_B)); // R2
  AST_CONFIRM_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == DW'(CODE_CONFIRM) && !s_ready && busy && $past(s_ready)
      |-> $past(wr_en) && wr_addr == $past(wr_addr)); // R7
  AST_DONE_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(wr_en) && $past(wr_data) == DW'(CODE_CONFIRM)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !wr_en && $past(start) && !$past(busy)); // R9
  AST_READY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && s_valid |-> wr_en && wr_data == s_data); // R6
endmodule

// File: tb/sim_nor_wrbuf_seq.sv
module sim_nor_wrbuf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24, DW = 16, CW = 8, DEPTH = 32;
  localparam int AMASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready, wr_en, busy, done, err;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int total = 0, bad = 0;

  // behavioural reference state
  int    qa[$], qd[$];
  string qt[$];
  int    m_rem = 0, m_cur = 0, m_last = 0, dseed = 16'h1234;
  bit    m_conf = 0, m_done = 0, m_err = 0;
  string ftag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_wrbuf_seq #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_cnt(word_cnt), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  function automatic bit m_busy();
    return (qa.size() > 0) || (m_rem > 0) || m_conf;
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tg, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit st, input int a, input int n, input bit v);
    bit e_wr, e_rdy, e_busy, was_done;
    int e_addr, e_data;
    string tg;
    @(negedge clk);
    start = st; start_addr = a[AW-1:0]; word_cnt = n[CW-1:0];
    s_valid = v; s_data = dseed[DW-1:0];
    dseed = (dseed * 13 + 7) & 16'hFFFF;
    #1;
    e_wr = 0; e_rdy = 0; e_addr = 0; e_data = 0; tg = "R9";
    e_busy = m_busy();
    if (qa.size() > 0) begin
      e_wr = 1; e_addr = qa[0]; e_data = qd[0]; tg = qt[0];
    end else if (m_rem > 0) begin
      e_rdy = 1; e_wr = v; e_addr = m_cur; e_data = int'(s_data); tg = "R5";
    end else if (m_conf) begin
      e_wr = 1; e_addr = m_last; e_data = 'h29; tg = "R7";
    end
    if (ftag != "") tg = ftag;
    chk(tg, "wr_en", wr_en, e_wr);
    if (e_wr) begin
      chk(tg, "wr_addr", wr_addr, e_addr);
      chk(tg, "wr_data", wr_data, e_data);
    end
    chk((ftag != "") ? ftag : "R6", "s_ready", s_ready, e_rdy);
    chk((ftag != "") ? ftag : "R8", "busy", busy, e_busy);
    chk("R8", "done", done, m_done);
    chk("R9", "err", err, m_err);
    // advance the model across the coming edge
    was_done = m_done;
    ftag = "";
    m_done = 0; m_err = 0;
    if (qa.size() > 0) begin
      void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
    end else if (m_rem > 0) begin
      if (v) begin m_last = m_cur; m_cur = (m_cur + 1) & AMASK; m_rem--; end
    end else if (m_conf) begin
      m_conf = 0; m_done = 1;
    end
    if (st && e_busy) ftag = "R10";
    if (st && !e_busy) begin
      if (n == 0 || n > DEPTH) m_err = 1;
      else begin
        qa.push_back('h555); qd.push_back('hAA); qt.push_back("R2");
        qa.push_back('h2AA); qd.push_back('h55); qt.push_back("R2");
        qa.push_back(a & AMASK); qd.push_back('h25); qt.push_back("R3");
        qa.push_back(a & AMASK); qd.push_back(n - 1); qt.push_back("R4");
        m_rem = n; m_cur = a & AMASK; m_conf = 1;
        if (was_done) ftag = "R11";
      end
    end
  endtask

  task automatic drain(input int gap);
    int k = 0;
    while (m_busy() || m_done || m_err) begin
      cyc(0, 0, 0, (gap == 0) ? 1'b1 : ((k % gap) != 0));
      k++;
    end
    cyc(0, 0, 0, 0);
  endtask

  task automatic burst(input int a, input int n, input int gap);
    cyc(1, a, n, 1);
    drain(gap);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
  localparam int WD_CYCLES = 20000;

  initial begin
    // R1: reset state, held and just after release
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "wr_en", wr_en, 0);
    chk("R1", "s_ready", s_ready, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    burst('h000100, 4, 0);          // R2 R3 R4 R5 R7 R8 plain burst
    burst('h000400, 5, 3);          // R6 stalls from the source
    burst('h000020, 1, 0);          // single word, confirm at start address
    burst('h001000, DEPTH, 2);      // largest legal burst
    cyc(1, 'h10, 0, 1); drain(0);   // R9 zero count
    cyc(1, 'h10, DEPTH + 1, 1); drain(0); // R9 count above depth
    // R10: start held high while busy
    cyc(1, 'h500, 2, 1);
    repeat (3) cyc(1, 'h900, 5, 1);
    drain(0);
    // R11: new request in the done cycle
    cyc(1, 'h2000, 2, 1);
    while (!m_done) cyc(0, 0, 0, 1);
    cyc(1, 'h3000, 3, 1);
    drain(2);
    burst(AMASK - 1, 4, 0);         // R5 address wrap
    cyc(1, 'h40, 2, 0); cyc(1, 'h80, 200, 0); drain(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule